// File: doc/BRIEF.md
# FIFO Occupancy Flag Generator

This block tracks how many words a first-in first-out buffer holds and turns that count into four active-low status flags: empty, full, more-than-half, and a combined edge flag. The edge flag is low near either end of the range: below one-eighth of the depth, or above seven-eighths of it. The buffer's write side pulses an increment strobe for each word it stores. The read side pulses a decrement strobe for each word it removes. The block holds the count itself and refuses a step that would take it below zero or above the depth, the same way the buffer's own full and empty guards refuse it.

All four flags are registered. Each one is computed from the count that the current strobes produce, so a flag changes on the same clock edge that applies the write or read crossing its threshold. A mode input tells whether the buffer stands alone. When the buffer is one element of a cascade, the edge flag is held high (inactive), because in that setting the pin carrying it is needed for other work. The depth is a parameter, and it must be a multiple of eight.

Top module: `occ_flags`

## Requirements
- R1: empty_n is low exactly when the count is 0, and full_n is low exactly when the count equals DEPTH.
- R2: half_n is low exactly when the count is greater than DEPTH/2. It is high for counts 0 through DEPTH/2 inclusive.
- R3: With single_mode high, almost_n is low when the count is below DEPTH/8 or above 7*DEPTH/8, and high for counts from DEPTH/8 to 7*DEPTH/8 inclusive. For DEPTH 256 it is low for 0..31 and for 225..256.
- R4: An increment strobe while the count equals DEPTH is ignored. A decrement strobe while the count is 0 is ignored. The count never wraps.
- R5: When both strobes are high in the same cycle and both are acceptable, the count is unchanged. At full only the decrement takes effect, and at empty only the increment takes effect.
- R6: While single_mode is low, almost_n is high from the first clock edge at which single_mode is sampled low.
- R7: An active-low rst_n clears the count to 0 at once, without waiting for a clock, and forces empty_n=0, full_n=1, half_n=1 and almost_n=0.
- R8: The flags are registered. A strobe that is applied at a rising edge is reflected in the flags just after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_inc | input | 1 | One word written this cycle |
| rd_dec | input | 1 | One word read this cycle |
| single_mode | input | 1 | High when the buffer stands alone; enables almost_n |
| empty_n | output | 1 | Low when the count is zero |
| full_n | output | 1 | Low when the count equals DEPTH |
| half_n | output | 1 | Low when the count is above DEPTH/2 |
| almost_n | output | 1 | Low near either end of the range (single mode only) |

## Verification
Three instances, with depths 256, 512 and 1024, share one set of strobes.

- **Full ramp and drain.** The shared strobes ramp the count up past the largest depth and then drain it back to zero, one word per cycle. Every threshold is crossed in both directions, and the smaller instances sit at saturation while the larger ones keep counting, which shows that ignored writes and reads do not wrap the count.
- **Both strobes at once.** Runs with both strobes high are placed at full, at empty and mid-range. They separate the three simultaneous-strobe cases: only a read takes effect at full, only a write takes effect at empty, and the count holds mid-range.
- **Cascade mode.** Stretches with single_mode low show that the edge flag is masked while the other three flags keep tracking the count.
- **Reset and timing.** Directed steps confirm that reset acts without a clock. A sample taken just before an edge and another just after it confirm that the flags are registered.

// File: rtl/occ_flags_pkg.sv
package occ_flags_pkg;

   typedef struct packed {
      logic empty_n;
      logic full_n;
      logic half_n;
      logic almost_n;
   } occ_flags_t;

   localparam occ_flags_t FLAGS_RST = '{empty_n: 1'b0, full_n: 1'b1,
                                        half_n: 1'b1, almost_n: 1'b0};

endpackage

// File: rtl/occ_counter.sv
module occ_counter #(
   parameter int DEPTH = 256,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_inc,
   input  logic          rd_dec,
   output logic [CW-1:0] cnt_nx
);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   logic [CW-1:0] cnt_q;
   logic          inc_ok;
   logic          dec_ok;

   always_comb begin
      inc_ok = wr_inc && (cnt_q != DEPTH_C);
      dec_ok = rd_dec && (cnt_q != '0);
      unique case ({inc_ok, dec_ok})
         2'b10:   cnt_nx = cnt_q + CW'(1);
         2'b01:   cnt_nx = cnt_q - CW'(1);
         default: cnt_nx = cnt_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nx;
   end

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= DEPTH_C);
   assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == DEPTH_C && wr_inc && !rd_dec) |=> cnt_q == DEPTH_C);
   assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && rd_dec && !wr_inc) |=> cnt_q == '0);
   assert_both_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_inc && rd_dec && cnt_q != '0 && cnt_q != DEPTH_C) |=> $stable(cnt_q));

endmodule

// File: rtl/occ_window.sv
module occ_window #(
   parameter int CW = 9,
   parameter int LO = 0,
   parameter int HI = 0
) (
   input  logic [CW-1:0] cnt,
   output logic          hit
);
   localparam logic [CW-1:0] LO_C = CW'(LO);
   localparam logic [CW-1:0] HI_C = CW'(HI);

   initial assert (LO <= HI) else $error("occ_window: LO above HI");

   generate
      if (LO == HI) begin : g_point
         assign hit = (cnt == LO_C);
      end else if (LO == 0) begin : g_upper
         assign hit = (cnt <= HI_C);
      end else begin : g_band
         assign hit = (cnt >= LO_C) && (cnt <= HI_C);
      end
   endgenerate

endmodule

// File: rtl/occ_flags.sv
module occ_flags
   import occ_flags_pkg::*;
#(
   parameter int DEPTH = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_inc,
   input  logic rd_dec,
   input  logic single_mode,
   output logic empty_n,
   output logic full_n,
   output logic half_n,
   output logic almost_n
);
   localparam int CW    = $clog2(DEPTH + 1);
   localparam int NWIN  = 4;
   // window order: zero, full, above half, middle band
   localparam int LO_B [NWIN] = '{0, DEPTH, DEPTH / 2 + 1, DEPTH / 8};
   localparam int HI_B [NWIN] = '{0, DEPTH, DEPTH, 7 * DEPTH / 8};

   initial assert (DEPTH >= 8 && DEPTH % 8 == 0)
      else $error("occ_flags: DEPTH must be a multiple of 8");

   logic [CW-1:0]   cnt_nx;
   logic [NWIN-1:0] hit;
   occ_flags_t      flags_d;
   occ_flags_t      flags_q;

   occ_counter #(.DEPTH(DEPTH), .CW(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_inc (wr_inc),
      .rd_dec (rd_dec),
      .cnt_nx (cnt_nx)
   );

   for (genvar i = 0; i < NWIN; i++) begin : g_win
      occ_window #(.CW(CW), .LO(LO_B[i]), .HI(HI_B[i])) u_win (
         .cnt (cnt_nx),
         .hit (hit[i])
      );
   end

   always_comb begin
      flags_d.empty_n  = !hit[0];
      flags_d.full_n   = !hit[1];
      flags_d.half_n   = !hit[2];
      flags_d.almost_n = hit[3] || !single_mode;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= FLAGS_RST;
      else        flags_q <= flags_d;
   end

   assign empty_n  = flags_q.empty_n;
   assign full_n   = flags_q.full_n;
   assign half_n   = flags_q.half_n;
   assign almost_n = flags_q.almost_n;

   assert_empty_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_n |-> (full_n && half_n));
   assert_full_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> !half_n);
   assert_edge_almost_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (single_mode && (!empty_n || !full_n)) |=> (!almost_n || (empty_n && full_n)));
   assert_multi_almost_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !single_mode |=> almost_n);

endmodule

// File: tb/occ_flags_tb_top.sv
module occ_flags_tb_top;
   localparam int ND = 3;
   localparam int DEP [ND] = '{256, 512, 1024};
   // segment: steps, inc, dec, single
   localparam int NSEG = 8;
   localparam int SEG [NSEG][4] = '{
      '{1030, 1, 0, 1}, '{4, 1, 1, 1}, '{1030, 0, 1, 1}, '{4, 1, 1, 1},
      '{300, 1, 0, 0},  '{6, 1, 1, 0}, '{400, 0, 1, 1},  '{10, 1, 0, 1}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_inc = 1'b0, rd_dec = 1'b0, single_mode = 1'b1;
   logic e_n [ND];
   logic f_n [ND];
   logic h_n [ND];
   logic a_n [ND];
   int   m [ND];
   logic sg_m = 1'b1;
   int   n_run = 0, n_fail = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   for (genvar k = 0; k < ND; k++) begin : g_d
      occ_flags #(.DEPTH(DEP[k])) dut_i (
         .clk(clk), .rst_n(rst_n), .wr_inc(wr_inc), .rd_dec(rd_dec),
         .single_mode(single_mode), .empty_n(e_n[k]), .full_n(f_n[k]),
         .half_n(h_n[k]), .almost_n(a_n[k]));
   end

   task automatic chk(input logic act, input logic exp, input string tag, input string what);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
      end
   endtask

   task automatic check_all();
      for (int k = 0; k < ND; k++) begin
         chk(e_n[k], m[k] != 0, "R1", $sformatf("empty_n d%0d n=%0d", DEP[k], m[k]));
         chk(f_n[k], m[k] != DEP[k], "R1", $sformatf("full_n d%0d n=%0d", DEP[k], m[k]));
         chk(h_n[k], m[k] <= DEP[k] / 2, "R2", $sformatf("half_n d%0d n=%0d", DEP[k], m[k]));
         chk(a_n[k], !sg_m || (m[k] >= DEP[k] / 8 && m[k] <= 7 * DEP[k] / 8),
             sg_m ? "R3" : "R6", $sformatf("almost_n d%0d n=%0d", DEP[k], m[k]));
      end
   endtask

   task automatic model_edge(input logic inc, input logic dec, input logic sg);
      for (int k = 0; k < ND; k++) begin
         int d;
         d = 0;
         if (inc && m[k] != DEP[k]) d = d + 1;
         if (dec && m[k] != 0) d = d - 1;
         m[k] = m[k] + d;
      end
      sg_m = sg;
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(input logic inc, input logic dec, input logic sg);
      wr_inc = inc; rd_dec = dec; single_mode = sg;
      @(posedge clk);
      model_edge(inc, dec, sg);
      @(negedge clk);
      check_all();
   endtask

   task automatic reset_checks();
      for (int k = 0; k < ND; k++) begin
         chk(e_n[k], 1'b0, "R7", "empty_n in reset");
         chk(f_n[k], 1'b1, "R7", "full_n in reset");
         chk(h_n[k], 1'b1, "R7", "half_n in reset");
         chk(a_n[k], 1'b0, "R7", "almost_n in reset");
      end
   endtask

   initial begin
      for (int k = 0; k < ND; k++) m[k] = 0;
      @(negedge clk);
      @(negedge clk);
      reset_checks();
      rst_n = 1'b1;

      for (int s = 0; s < NSEG; s++)
         for (int n = 0; n < SEG[s][0]; n++)
            step(SEG[s][1] != 0, SEG[s][2] != 0, SEG[s][3] != 0);

      // mid-run reset acts without a clock edge
      wr_inc = 1'b0; rd_dec = 1'b0;
      #1 rst_n = 1'b0;
      #0.5;
      reset_checks();
      for (int k = 0; k < ND; k++) m[k] = 0;
      @(negedge clk);
      rst_n = 1'b1;

      // registered output: unchanged before the edge, updated after it
      wr_inc = 1'b1; single_mode = 1'b1;
      #1;
      for (int k = 0; k < ND; k++) chk(e_n[k], 1'b0, "R8", "empty_n before edge");
      @(posedge clk);
      model_edge(1'b1, 1'b0, 1'b1);
      @(negedge clk);
      for (int k = 0; k < ND; k++) chk(e_n[k], 1'b1, "R8", "empty_n after edge");

      // writes at full are dropped; one read then leaves full
      for (int n = 0; n < 1030; n++) step(1'b1, 1'b0, 1'b1);
      step(1'b0, 1'b1, 1'b1);
      for (int k = 0; k < ND; k++) begin
         chk(f_n[k], 1'b1, "R4", "full_n after one read past saturation");
         chk(h_n[k], 1'b0, "R4", "half_n after one read past saturation");
      end

      // simultaneous strobes: hold below full, only the read at full
      step(1'b1, 1'b1, 1'b1);
      for (int k = 0; k < ND; k++) chk(f_n[k], 1'b1, "R5", "full_n with both at D-1");
      step(1'b1, 1'b0, 1'b1);
      for (int k = 0; k < ND; k++) chk(f_n[k], 1'b0, "R5", "full_n reached");
      step(1'b1, 1'b1, 1'b1);
      for (int k = 0; k < ND; k++) chk(f_n[k], 1'b1, "R5", "full_n after both at full");

      // cascade mode masks almost_n while near the edge
      step(1'b0, 1'b0, 1'b0);
      for (int k = 0; k < ND; k++) chk(a_n[k], 1'b1, "R6", "almost_n masked near full");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule